// File: doc/BRIEF.md
# Memory-Mapped Instruction Fetch Decoder

This block is the front end of a register-free processor whose program counter is an ordinary 32-bit little-endian word kept in shared byte-addressed memory at address 0. Over one synchronous byte-wide memory port it reads that word, reads the instruction's first byte, and classifies the instruction. It then collects the operand words that follow and stores the advanced counter back into bytes 0 to 3. Only after that does it present the decoded instruction to an execute stage.

The first byte selects everything. Its top bit picks a 5-byte form with one operand or a 9-byte form with two operands. Its low seven bits are an opcode, and each form numbers its opcodes separately. A first byte of 0xFF stops the machine cleanly. An opcode that is not implemented, or any instruction byte that lies beyond the implemented memory, stops it with a fault. The execute stage raises `done` to request the next fetch. Because the counter has already been advanced, the next fetch starts from the updated counter, or from whatever value the execute stage wrote there.

Top module: `insn_fetch_decode`

## Requirements
- R1: After `start` (from idle, halt or fault) or `done` (while a decoded instruction is presented), the block reads memory bytes 0,1,2,3 as a little-endian counter and fetches the first instruction byte from that counter address.
- R2: A first byte of 0xFF raises `halt`. No counter write-back happens. `halt` stays high with no memory access until `start`.
- R3: First-byte bit 7 = 0 selects a 5-byte instruction with `dec_nops` = 1. Bit 7 = 1 selects a 9-byte instruction with `dec_nops` = 2.
- R4: `dec_opcode` equals bits 6:0 of the first byte.
- R5: Operand A is the little-endian word at counter+1..+4. For the long form, operand B is the little-endian word at counter+5..+8. For the short form, `dec_op_b` reads 0.
- R6: Short-form opcodes 0..SHORT_OPS-1 (0..1) and long-form opcodes 0..LONG_OPS-1 (0..19) are legal. Any other opcode raises `fault` without a counter write-back.
- R7: An instruction byte address of MEM_BYTES or more, computed without 32-bit wrap, raises `fault` without reading that address. This check is made in the cycle the read would have been issued.
- R8: The counter plus 5 (short) or plus 9 (long), modulo 2^32, is written little-endian to bytes 0..3 before `dec_valid` rises.
- R9: `dec_valid` and all decoded fields stay steady until `done`.
- R10: Each byte read takes two cycles. Counting clock edges from the one that accepts `start` or `done` as edge 1, `dec_valid` is first seen after edge 23 (short form) or edge 31 (long form), and `halt` or an opcode fault after edge 11. A range fault on read index i (counter bytes are indices 0..3, the first byte is index 4) is seen after edge 2+2i. `busy` is high while fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching from idle, halt or fault |
| done | input | 1 | Execute stage finished; fetch next instruction |
| mem_addr | output | 32 | Memory byte address |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write request of `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Fetch or write-back in progress |
| dec_valid | output | 1 | Decoded instruction presented |
| dec_opcode | output | 7 | Opcode within its form |
| dec_nops | output | 2 | Operand count, 1 or 2 |
| dec_op_a | output | 32 | Operand A field |
| dec_op_b | output | 32 | Operand B field, 0 for the short form |
| halt | output | 1 | Clean stop on first byte 0xFF |
| fault | output | 1 | Stop on illegal opcode or out-of-range address |

## Verification
Every result has a fixed latency. Two cycles per byte read plus four write cycles give 23 edges for the short form and 31 for the long form. Halt and opcode faults take 11 edges, and a range fault on read index i takes 2+2i. The bench counts edges from the one that accepts `start` or `done` and samples all outputs on falling edges. It requires the outcome to appear at exactly the predicted count and checks the memory's counter bytes in that same cycle. A fixed latency like this means one missing or extra register moves the outcome off its predicted edge, so such a change shows up as a miscompare rather than passing unnoticed.

// File: rtl/insn_fetch_decode.sv
module insn_fetch_decode #(
  parameter int MEM_BYTES = 65536,
  parameter int SHORT_OPS = 2,
  parameter int LONG_OPS  = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        done,
  output logic [31:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        dec_valid,
  output logic [6:0]  dec_opcode,
  output logic [1:0]  dec_nops,
  output logic [31:0] dec_op_a,
  output logic [31:0] dec_op_b,
  output logic        halt,
  output logic        fault
);

  localparam logic [3:0] IDX_HEAD   = 4'd4;
  localparam logic [3:0] LAST_SHORT = 4'd8;
  localparam logic [3:0] LAST_LONG  = 4'd12;
  localparam logic [7:0] HALT_BYTE  = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CAP, S_WR, S_ISSUE, S_HALT, S_FAULT} state_t;

  state_t      st;
  logic [3:0]  idx;
  logic [1:0]  widx;
  logic [31:0] pc;
  logic [7:0]  head;
  logic [31:0] opa, opb;

  logic [32:0] fetch_addr;
  logic        in_range;
  logic [31:0] next_pc;
  logic [3:0]  bsel;
  logic        at_last;

  function automatic logic legal(input logic [7:0] b);
    legal = b[7] ? (int'(b[6:0]) < LONG_OPS) : (int'(b[6:0]) < SHORT_OPS);
  endfunction

  assign fetch_addr = {1'b0, pc} + {29'd0, idx} - 33'd4;
  assign in_range   = (idx < IDX_HEAD) || (fetch_addr < 33'(MEM_BYTES));
  assign next_pc    = pc + (head[7] ? 32'd9 : 32'd5);
  assign bsel       = idx - 4'd1;
  assign at_last    = (idx > IDX_HEAD) && (idx == (head[7] ? LAST_LONG : LAST_SHORT));

  assign mem_rd    = (st == S_REQ) && in_range;
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = (st == S_WR)  ? {30'd0, widx} :
                     (st == S_REQ) ? ((idx < IDX_HEAD) ? {28'd0, idx} : fetch_addr[31:0]) : 32'd0;
  assign mem_wdata = next_pc[{widx, 3'b000} +: 8];

  assign busy       = (st == S_REQ) || (st == S_CAP) || (st == S_WR);
  assign dec_valid  = (st == S_ISSUE);
  assign halt       = (st == S_HALT);
  assign fault      = (st == S_FAULT);
  assign dec_opcode = head[6:0];
  assign dec_nops   = head[7] ? 2'd2 : 2'd1;
  assign dec_op_a   = opa;
  assign dec_op_b   = opb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= 4'd0;
      widx <= 2'd0;
      pc   <= 32'd0;
      head <= 8'd0;
      opa  <= 32'd0;
      opb  <= 32'd0;
    end else begin
      case (st)
        S_IDLE, S_HALT, S_FAULT:
          if (start) begin
            st  <= S_REQ;
            idx <= 4'd0;
            opb <= 32'd0;
          end
        S_REQ:
          st <= in_range ? S_CAP : S_FAULT;
        S_CAP: begin
          if (idx < IDX_HEAD)       pc[{idx[1:0], 3'b000} +: 8]  <= mem_rdata;
          else if (idx == IDX_HEAD) head                         <= mem_rdata;
          else if (idx < 4'd9)      opa[{bsel[1:0], 3'b000} +: 8] <= mem_rdata;
          else                      opb[{bsel[1:0], 3'b000} +: 8] <= mem_rdata;
          if (idx == IDX_HEAD && mem_rdata == HALT_BYTE)
            st <= S_HALT;
          else if (idx == IDX_HEAD && !legal(mem_rdata))
            st <= S_FAULT;
          else if (at_last) begin
            st   <= S_WR;
            widx <= 2'd0;
          end else begin
            st  <= S_REQ;
            idx <= idx + 4'd1;
          end
        end
        S_WR: begin
          widx <= widx + 2'd1;
          if (widx == 2'd3) st <= S_ISSUE;
        end
        S_ISSUE:
          if (done) begin
            st  <= S_REQ;
            idx <= 4'd0;
            opb <= 32'd0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R8
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> ({1'b0, mem_addr} < 33'(MEM_BYTES))); // R7
  AST_WB_COUNTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> (mem_addr < 32'd4)); // R8
  AST_WB_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(dec_valid) |-> ($past(mem_wr) && $past(mem_addr) == 32'd3)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (halt && !start) |=> (halt && !mem_rd && !mem_wr)); // R2
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && !done) |=> (dec_valid && $stable(dec_op_a) && $stable(dec_op_b) && $stable(dec_opcode))); // R9
  AST_SHORT_NO_B: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && dec_nops == 2'd1) |-> (dec_op_b == 32'd0)); // R5
  AST_EXCL_STATUS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({dec_valid, halt, fault, busy})); // R10

endmodule

// File: tb/test_insn_fetch_decode.sv
module test_insn_fetch_decode;
  localparam int MEMB = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, done = 0;
  logic [31:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 0;
  logic        busy, dec_valid, halt, fault;
  logic [6:0]  dec_opcode;
  logic [1:0]  dec_nops;
  logic [31:0] dec_op_a, dec_op_b;

  logic        tb_we = 0;
  logic [5:0]  tb_a = 0;
  logic [7:0]  tb_d = 0;
  logic [7:0]  mem [MEMB];

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  insn_fetch_decode #(.MEM_BYTES(MEMB), .SHORT_OPS(2), .LONG_OPS(20)) i_insn_fetch_decode (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_nops(dec_nops),
    .dec_op_a(dec_op_a), .dec_op_b(dec_op_b), .halt(halt), .fault(fault));

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_wr && mem_addr < MEMB) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk); tb_we = 1; tb_a = a[5:0]; tb_d = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic set_pc(input logic [31:0] p);
    for (int k = 0; k < 4; k++) poke(k, p[8*k +: 8]);
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  function automatic logic [7:0] obyte(input int p, input int k, input int b);
    return 8'(p * 7 + k * 29 + b * 3 + 1);
  endfunction

  // Drives start and done together; counts edges to the outcome.
  task automatic launch(output int n, input string req);
    @(negedge clk); start = 1; done = 1; n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) chk({req, "/R10 busy"}, busy, 1);
      start = 0; done = 0;
    end while (!(dec_valid || halt || fault) && n < 200);
    if (n >= 200) chk({req, " timeout"}, 0, 1);
  endtask

  initial begin
    #(8 * 190000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < MEMB; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset dec_valid", dec_valid, 0);
    chk("reset halt", halt, 0);
    chk("reset fault", fault, 0);
    chk("reset mem access", {mem_rd, mem_wr}, 0);

    // Sweep every first-byte value (R1 R2 R3 R4 R5 R6 R8 R10 R11-style restart).
    for (int b = 0; b < 256; b++) begin
      int p;
      bit lng, ok;
      logic [31:0] ea, eb;
      p = 4 + (b % 48);
      lng = b[7];
      ok = lng ? ((b & 127) < 20) : ((b & 127) < 2);
      set_pc(p);
      poke(p, 8'(b));
      for (int k = 0; k < 8; k++) poke(p + 1 + k, obyte(p, k, b));
      ea = {obyte(p, 3, b), obyte(p, 2, b), obyte(p, 1, b), obyte(p, 0, b)};
      eb = lng ? {obyte(p, 7, b), obyte(p, 6, b), obyte(p, 5, b), obyte(p, 4, b)} : 32'd0;
      launch(n, "sweep");
      if (b == 255) begin
        chk("R2 halt", {halt, fault, dec_valid}, 3'b100);
        chk("R2/R10 halt latency", n, 11);
        chk("R2 no writeback", rd32(0), p);
      end else if (!ok) begin
        chk("R6 opcode fault", {halt, fault, dec_valid}, 3'b010);
        chk("R6/R10 fault latency", n, 11);
        chk("R6 no writeback", rd32(0), p);
      end else begin
        chk("R1 valid", {halt, fault, dec_valid}, 3'b001);
        chk("R4 opcode", dec_opcode, b & 127);
        chk("R3 nops", dec_nops, lng ? 2 : 1);
        chk("R5 operand A", dec_op_a, ea);
        chk("R5 operand B", dec_op_b, eb);
        chk("R8 writeback", rd32(0), p + (lng ? 9 : 5));
        chk("R10 valid latency", n, lng ? 31 : 23);
      end
    end

    // Address range (R7), short at the top edge fits.
    set_pc(59); poke(59, 8'h01);
    for (int k = 0; k < 4; k++) poke(60 + k, 8'(k + 5));
    launch(n, "R7 edge");
    chk("R7 short fits valid", dec_valid, 1);
    chk("R7 short fits latency", n, 23);
    chk("R7 short fits opA", dec_op_a, 32'h08070605);
    chk("R8 writeback to 64", rd32(0), 64);

    set_pc(60); poke(60, 8'h00);
    launch(n, "R7 short over");
    chk("R7 short over fault", {fault, dec_valid}, 2'b10);
    chk("R7 short over latency", n, 18);
    chk("R7 no writeback", rd32(0), 60);

    set_pc(56); poke(56, 8'h80);
    launch(n, "R7 long over");
    chk("R7 long over fault", fault, 1);
    chk("R7 long over latency", n, 26);

    set_pc(32'hFFFF_FFFF);
    launch(n, "R7 wrap");
    chk("R7 wrap fault", fault, 1);
    chk("R7 wrap latency", n, 10);

    // Chained program with done handshake (R9 R1 R8).
    set_pc(20);
    poke(20, 8'h00); poke(21, 8'h0B); poke(22, 8'h16); poke(23, 8'h21); poke(24, 8'h2C);
    poke(25, 8'h93);
    for (int k = 0; k < 8; k++) poke(26 + k, 8'(8'hA0 + k));
    poke(34, 8'hFF);
    launch(n, "chain1");
    chk("R1 chain short valid", dec_valid, 1);
    chk("R5 chain opA", dec_op_a, 32'h2C21160B);
    repeat (3) @(negedge clk);
    chk("R9 held valid", dec_valid, 1);
    chk("R9 held opA", dec_op_a, 32'h2C21160B);
    chk("R9 counter after short", rd32(0), 25);
    launch(n, "chain2");
    chk("R9 done refetch valid", dec_valid, 1);
    chk("R9 done latency", n, 31);
    chk("R4 chain opcode", dec_opcode, 19);
    chk("R5 chain opB", dec_op_b, 32'hA7A6A5A4);
    chk("R8 chain counter", rd32(0), 34);
    launch(n, "chain3");
    chk("R2 chain halt", halt, 1);
    repeat (4) @(negedge clk);
    chk("R2 halt sticky", {halt, mem_rd, mem_wr}, 3'b100);
    chk("R2 counter kept", rd32(0), 34);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule